// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

This block lets a bus master read a serial NOR flash as plain memory. While the map enable is high, each word request on the request channel becomes a read frame on the flash pins. The frame asserts chip select and sends an optional opcode byte. It then sends the address, runs a number of idle dummy clocks and shifts in data. Four received bytes are packed into one 32-bit word, which goes back on the response channel. The frame format comes from a packed 24-bit control word and a separate opcode input. Together they select single, dual-output, dual-IO, quad-output or quad-IO reads, with 3-byte or 4-byte addressing.

Both bus channels use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high on a rising clock edge. A response stays valid, with unchanged data, until `resp_ready` is seen high. After a word is delivered, chip select stays low and the serial clock stops. If the next request is for the following word address, the frame continues with data clocks only. Any other request, or dropping the enable, closes the frame. The `host_mode_ok` output tells the register-driven transfer logic when it may use the pins.

Top module: `flash_mmap_reader`

## Requirements
- R1: With `mm_en` low and no frame open, `req_ready` is 0, `spi_cs_n` stays 1, `spi_sck` stays 0 and `host_mode_ok` is 1.
- R2: An accepted request drives `spi_cs_n` low in the next cycle. When `xfer_cfg[11]` is 1, the frame opens with the 8 bits of `rd_opcode`, most significant bit first, on `spi_io_out[0]` only. Each bit is stable while `spi_sck` is high.
- R3: `xfer_cfg[10:8]` gives the address byte count (0, 3 or 4; values above 4 act as 4). Address bytes are sent most significant byte first, from the word-aligned request address. With 3 bytes, address bits 31:24 are dropped.
- R4: After the address, `xfer_cfg[19:16]` serial clocks (0 to 15) run with every `spi_io_oe` bit at 0.
- R5: `xfer_cfg[5:4]` sets the data lane count: 0 gives one lane on `spi_io_in[1]`, 1 gives two lanes on `spi_io_in[1:0]`, and 2 gives four lanes on `spi_io_in[3:0]`. In each clock, the higher lane carries the earlier bit of a byte, and each byte is sent MSB first.
- R6: When `xfer_cfg[3]` (fast) is 1 and the data lane count is more than one, the address is sent on that same lane count. Otherwise the address is sent on `spi_io_out[0]` alone.
- R7: The response word holds four consecutive flash bytes, with the lowest address in bits 7:0. `resp_valid` and `resp_data` are held until `resp_ready`.
- R8: While enabled, a request for the previous word address plus 4 keeps `spi_cs_n` low and continues with data clocks only. Any other request first raises `spi_cs_n` for at least one cycle, then starts a new frame.
- R9: Clearing `mm_en` during a frame does not cut off the current word, which is still delivered. `spi_cs_n` then rises, and `host_mode_ok` is 1 only after that.
- R10: With `xfer_cfg[11]`, address count and dummy count all zero, the frame consists of data clocks only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_en | input | 1 | Memory-mapped read mode enable |
| xfer_cfg | input | 24 | Packed frame format word |
| rd_opcode | input | 8 | Read opcode sent at frame start |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_addr | input | 32 | Byte address of the requested word |
| resp_valid | output | 1 | Read data valid |
| resp_ready | input | 1 | Master takes read data |
| resp_data | output | 32 | Assembled read word |
| host_mode_ok | output | 1 | Pins free for register-driven transfers |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_io_out | output | 4 | Output values for the flash IO lines |
| spi_io_oe | output | 4 | Output enables for the flash IO lines |
| spi_io_in | input | 4 | Values read from the flash IO lines |

## Verification
A behavioural flash model decodes the opcode and address from the pins. It answers with a byte pattern derived from the address. Six read types are run with both 3-byte and 4-byte addressing. Addresses with a non-zero top byte show whether the 3-byte form drops that byte, and the IO variants show whether the address moves onto the wide lanes. A data-only format and back-to-back sequential words check the phase skipping. Non-sequential reads, a stalled response and an enable drop mid-frame check how the frame is closed and how the handshake holds.

// File: rtl/frd_pkg.sv
package frd_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DUM, ST_DAT, ST_RESP, ST_HOLD, ST_END
  } frd_state_e;

  typedef struct packed {
    logic       has_op;
    logic [2:0] abytes;
    logic [3:0] dummy;
    logic [2:0] dlanes;
    logic [2:0] alanes;
  } frame_fmt_t;

  function automatic frame_fmt_t fmt_decode(logic [23:0] w);
    frame_fmt_t f;
    logic [2:0] dl;
    case (w[5:4])
      2'b01:   dl = 3'd2;
      2'b10:   dl = 3'd4;
      default: dl = 3'd1;
    endcase
    f.has_op = w[11];
    f.abytes = (w[10:8] > 3'd4) ? 3'd4 : w[10:8];
    f.dummy  = w[19:16];
    f.dlanes = dl;
    f.alanes = (w[3] && dl != 3'd1) ? dl : 3'd1;
    return f;
  endfunction

  function automatic logic [8:0] beats(logic [8:0] bits, logic [2:0] lanes);
    case (lanes)
      3'd4:    return bits >> 2;
      3'd2:    return bits >> 1;
      default: return bits;
    endcase
  endfunction
endpackage

// File: rtl/frd_tx.sv
module frd_tx #(
  parameter int SH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SH_W-1:0] load_val,
  input  logic            shift,
  input  logic [2:0]      lanes,
  output logic [3:0]      top
);
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else if (load) sh <= load_val;
    else if (shift) begin
      case (lanes)
        3'd4:    sh <= sh << 4;
        3'd2:    sh <= sh << 2;
        default: sh <= sh << 1;
      endcase
    end
  end

  assign top = sh[SH_W-1 -: 4];
endmodule

// File: rtl/frd_rx.sv
module frd_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample,
  input  logic [2:0]        lanes,
  input  logic [3:0]        io_in,
  output logic [DATA_W-1:0] word
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDXW  = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [7:0]      byte_sh, nb;
  logic [3:0]      bitc, nbits;
  logic [IDXW-1:0] idx;

  always_comb begin
    case (lanes)
      3'd4:    nb = {byte_sh[3:0], io_in};
      3'd2:    nb = {byte_sh[5:0], io_in[1:0]};
      default: nb = {byte_sh[6:0], io_in[1]};
    endcase
    nbits = bitc + {1'b0, lanes};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_sh <= '0;
      bitc    <= '0;
      idx     <= '0;
      word    <= '0;
    end else if (clr) begin
      bitc <= '0;
      idx  <= '0;
    end else if (sample) begin
      byte_sh <= nb;
      if (nbits == 4'd8) begin
        word[{idx, 3'b000} +: 8] <= nb;
        idx  <= (32'(idx) == BYTES - 1) ? '0 : idx + 1'b1;
        bitc <= '0;
      end else begin
        bitc <= nbits;
      end
    end
  end
endmodule

// File: rtl/frd_seq.sv
module frd_seq
  import frd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_en,
  input  frame_fmt_t        fmt_in,
  input  logic [7:0]        op_in,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic              host_mode_ok,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        io_oe,
  output logic [2:0]        cur_lanes,
  output logic              tx_load,
  output logic [31:0]       tx_val,
  output logic              tx_shift,
  output logic              rx_clr,
  output logic              rx_sample
);
  localparam logic [8:0]        DATA_BITS = 9'(DATA_W);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(DATA_W / 8);

  frd_state_e        state, tgt;
  frame_fmt_t        fq, fuse;
  logic [7:0]        opq;
  logic [ADDR_W-1:0] aq, nxt_addr, req_al, ause;
  logic [8:0]        cnt, tgt_cnt;
  logic              half, cs_q;
  logic              active, beat_end, last_beat, seq_hit, accept;

  function automatic frd_state_e after_phase(frd_state_e ph, frame_fmt_t f);
    if (ph == ST_IDLE && f.has_op) return ST_OPC;
    if ((ph == ST_IDLE || ph == ST_OPC) && f.abytes != 3'd0) return ST_ADR;
    if (ph != ST_DUM && f.dummy != 4'd0) return ST_DUM;
    return ST_DAT;
  endfunction

  always_comb begin
    req_al    = {req_addr[ADDR_W-1:2], 2'b00};
    active    = state inside {ST_OPC, ST_ADR, ST_DUM, ST_DAT};
    beat_end  = active && half;
    last_beat = beat_end && cnt == 9'd1;
    seq_hit   = state == ST_HOLD && mm_en && req_valid && req_al == nxt_addr;
    req_ready = mm_en && (state == ST_IDLE || seq_hit);
    accept    = req_valid && req_ready;
    fuse      = (state == ST_IDLE) ? fmt_in : fq;
    ause      = (state == ST_IDLE) ? req_al : aq;
    tgt       = after_phase(state, fuse);
    case (tgt)
      ST_OPC:  tgt_cnt = 9'd8;
      ST_ADR:  tgt_cnt = beats(9'(fuse.abytes) << 3, fuse.alanes);
      ST_DUM:  tgt_cnt = 9'(fuse.dummy);
      default: tgt_cnt = beats(DATA_BITS, fuse.dlanes);
    endcase
    if (tgt == ST_OPC) tx_val = {((state == ST_IDLE) ? op_in : opq), 24'h0};
    else               tx_val = ause << (6'd8 * (6'd4 - 6'(fuse.abytes)));
    tx_load   = (state == ST_IDLE && accept) || (last_beat && state != ST_DAT);
    tx_shift  = beat_end;
    rx_sample = beat_end && state == ST_DAT;
    rx_clr    = state == ST_IDLE && accept;
    case (state)
      ST_OPC:  cur_lanes = 3'd1;
      ST_ADR:  cur_lanes = fq.alanes;
      default: cur_lanes = fq.dlanes;
    endcase
    case (state)
      ST_OPC:  io_oe = 4'b0001;
      ST_ADR:  io_oe = (fq.alanes == 3'd4) ? 4'b1111 :
                       (fq.alanes == 3'd2) ? 4'b0011 : 4'b0001;
      default: io_oe = 4'b0000;
    endcase
    sck          = half;
    cs_n         = cs_q;
    resp_valid   = state == ST_RESP;
    host_mode_ok = state == ST_IDLE && !mm_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half     <= 1'b0;
      cnt      <= '0;
      cs_q     <= 1'b1;
      fq       <= '0;
      opq      <= '0;
      aq       <= '0;
      nxt_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          fq       <= fmt_in;
          opq      <= op_in;
          aq       <= req_al;
          nxt_addr <= req_al + STEP;
          state    <= tgt;
          cnt      <= tgt_cnt;
          cs_q     <= 1'b0;
          half     <= 1'b0;
        end
        ST_OPC, ST_ADR, ST_DUM, ST_DAT: begin
          half <= ~half;
          if (beat_end) begin
            if (cnt == 9'd1) begin
              if (state == ST_DAT) state <= ST_RESP;
              else begin
                state <= tgt;
                cnt   <= tgt_cnt;
              end
            end else cnt <= cnt - 9'd1;
          end
        end
        ST_RESP: if (resp_ready) begin
          if (mm_en) state <= ST_HOLD;
          else begin
            state <= ST_END;
            cs_q  <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (!mm_en || (req_valid && !seq_hit)) begin
            state <= ST_END;
            cs_q  <= 1'b1;
          end else if (accept) begin
            state    <= ST_DAT;
            cnt      <= beats(DATA_BITS, fq.dlanes);
            nxt_addr <= nxt_addr + STEP;
          end
        end
        ST_END:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted request opens the frame with the clock low
  p_start_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && accept) |=> (!cs_n && !sck));
  // R8: no serial clock outside an open frame
  p_sck_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R8: a held frame keeps chip select low with the clock parked
  p_hold_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (!cs_n && !sck));
  // R9: pins are handed back only once chip select is released
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_mode_ok) |-> (cs_n && $past(cs_n)));
  // R1: host mode means no frame on the pins
  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode_ok |-> (cs_n && !req_ready));
endmodule

// File: rtl/flash_mmap_reader.sv
module flash_mmap_reader
  import frd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_en,
  input  logic [23:0]       xfer_cfg,
  input  logic [7:0]        rd_opcode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              host_mode_ok,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic [3:0]        spi_io_out,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_in
);
  frame_fmt_t  fmt;
  logic [2:0]  lanes;
  logic        tx_load, tx_shift, rx_clr, rx_sample;
  logic [31:0] tx_val;
  logic [3:0]  tx_top;

  assign fmt = fmt_decode(xfer_cfg);

  frd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .fmt_in(fmt), .op_in(rd_opcode),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .resp_ready(resp_ready), .resp_valid(resp_valid), .host_mode_ok(host_mode_ok),
    .cs_n(spi_cs_n), .sck(spi_sck), .io_oe(spi_io_oe), .cur_lanes(lanes),
    .tx_load(tx_load), .tx_val(tx_val), .tx_shift(tx_shift),
    .rx_clr(rx_clr), .rx_sample(rx_sample)
  );

  frd_tx #(.SH_W(32)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .lanes(lanes), .top(tx_top)
  );

  frd_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .sample(rx_sample),
    .lanes(lanes), .io_in(spi_io_in), .word(resp_data)
  );

  always_comb begin
    case (lanes)
      3'd4:    spi_io_out = tx_top;
      3'd2:    spi_io_out = {2'b00, tx_top[3:2]};
      default: spi_io_out = {3'b000, tx_top[3]};
    endcase
    spi_io_out = spi_io_out & spi_io_oe;
  end

  // R7: a stalled response keeps its word
  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));
  // R7: a word is delivered while its frame is still open
  p_resp_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !spi_cs_n);
endmodule

// File: tb/flash_mmap_reader_bench.sv
module flash_mmap_reader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mm_en = 1'b0;
  logic [23:0] xfer_cfg = '0;
  logic [7:0]  rd_opcode = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        resp_ready = 1'b0;
  logic        req_ready, resp_valid, host_mode_ok, spi_cs_n, spi_sck;
  logic [31:0] resp_data;
  logic [3:0]  spi_io_out, spi_io_oe, spi_io_in;

  always #2 clk = ~clk;

  flash_mmap_reader u_flash_mmap_reader (
    .clk(clk), .rst_n(rst_n), .mm_en(mm_en), .xfer_cfg(xfer_cfg),
    .rd_opcode(rd_opcode), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .host_mode_ok(host_mode_ok), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .spi_io_in(spi_io_in)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // expected frame shape, derived from the requirements
  int m_op, m_alw, m_ab, m_dl, m_aclk, m_pre;

  task automatic set_cfg(input logic [23:0] c, input logic [7:0] op);
    xfer_cfg  = c;
    rd_opcode = op;
    m_op  = c[11] ? 8 : 0;
    m_ab  = (c[10:8] > 3'd4) ? 4 : int'(c[10:8]);
    m_dl  = (c[5:4] == 2'b01) ? 2 : (c[5:4] == 2'b10) ? 4 : 1;
    m_alw = (c[3] && m_dl > 1) ? m_dl : 1;
    m_aclk = m_ab * 8 / m_alw;
    m_pre = m_op + m_aclk + int'(c[19:16]);
  endtask

  function automatic logic [7:0] mem(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5C;
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] b);
    return {mem(b + 32'd3), mem(b + 32'd2), mem(b + 32'd1), mem(b)};
  endfunction

  // behavioural flash
  int nr, nf, frames = 0;
  logic [7:0]  op_cap;
  logic [31:0] addr_cap;
  logic        dum_bad = 1'b0;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      nr <= 0; op_cap <= '0; addr_cap <= '0;
    end else begin
      if (nr < m_op) op_cap <= {op_cap[6:0], spi_io_out[0]};
      else if (nr < m_op + m_aclk) begin
        case (m_alw)
          4:       addr_cap <= {addr_cap[27:0], spi_io_out};
          2:       addr_cap <= {addr_cap[29:0], spi_io_out[1:0]};
          default: addr_cap <= {addr_cap[30:0], spi_io_out[0]};
        endcase
      end else if (nr < m_pre && spi_io_oe != 4'h0) dum_bad <= 1'b1;
      nr <= nr + 1;
    end
  end

  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) nf <= 0;
    else nf <= nf + 1;
  end

  always @(negedge spi_cs_n) frames++;

  function automatic logic [3:0] model_io(int nfv, int prev, int dl,
                                          logic [31:0] base, logic open);
    int bitpos;
    logic [7:0] sb;
    if (!open || nfv < prev) return 4'h0;
    bitpos = (nfv - prev) * dl;
    sb = mem(base + 32'(bitpos / 8)) << (bitpos % 8);
    case (dl)
      4:       return sb[7:4];
      2:       return {2'b00, sb[7:6]};
      default: return {2'b00, sb[7], 1'b0};
    endcase
  endfunction

  assign spi_io_in = model_io(nf, m_pre, m_dl, addr_cap, !spi_cs_n);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    d = resp_data;
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  function automatic logic [31:0] base_of(logic [31:0] a);
    if (m_ab == 0) return 32'h0;
    if (m_ab == 3) return {8'h00, a[23:0]};
    return a;
  endfunction

  // {opcode, control word, address}
  localparam logic [63:0] VEC [13] = '{
    {8'h03, 24'h003B81, 32'hA5123450},
    {8'h0B, 24'h083B89, 32'h00FF0100},
    {8'h3B, 24'h083B91, 32'h7E00A008},
    {8'hBB, 24'h043B99, 32'h0013570C},
    {8'h6B, 24'h083BA1, 32'hC0FFEE10},
    {8'hEB, 24'h063BA9, 32'h00ABCD24},
    {8'h13, 24'h303C81, 32'h12345678},
    {8'h0C, 24'h383C89, 32'hFEDCBA90},
    {8'h3C, 24'h383C91, 32'h01020304},
    {8'hBC, 24'h343C99, 32'h80000400},
    {8'h6C, 24'h383CA1, 32'h5A5A5A58},
    {8'hEC, 24'h363CA9, 32'h33330010},
    {8'h00, 24'h000011, 32'h00000800}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R7: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int f0;
    set_cfg(24'h003B81, 8'h03);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cs_n", 32'(spi_cs_n), 32'd1);
    chk("reset sck", 32'(spi_sck), 32'd0);
    chk("reset resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 host_mode_ok", 32'(host_mode_ok), 32'd1);
    req_valid = 1'b1;
    req_addr  = 32'h100;
    #1;
    chk("R1 req_ready off", 32'(req_ready), 32'd0);
    repeat (20) @(negedge clk);
    chk("R1 cs_n stays high", 32'(spi_cs_n), 32'd1);
    chk("R1 no frames", 32'(frames), 32'd0);
    req_valid = 1'b0;
    mm_en = 1'b1;

    for (int i = 0; i < 13; i++) begin
      logic [31:0] a;
      a = VEC[i][31:0];
      @(negedge clk);
      set_cfg(VEC[i][55:32], VEC[i][63:56]);
      dum_bad = 1'b0;
      do_read(a, d);
      if (m_op == 0) chk("R10 data-only word", d, exp_word(base_of(a)));
      else chk("R5 data word", d, exp_word(base_of(a)));
      if (m_op != 0) chk("R2 opcode", 32'(op_cap), 32'(VEC[i][63:56]));
      if (m_ab != 0) begin
        if (m_alw > 1) chk("R6 wide address", addr_cap, base_of(a));
        else chk("R3 address", addr_cap, base_of(a));
      end
      chk("R4 dummy lines released", 32'(dum_bad), 32'd0);
    end

    // R8 sequential continuation and non-sequential restart
    @(negedge clk);
    set_cfg(24'h063BA9, 8'hEB);
    do_read(32'h00002000, d);
    chk("R8 first word", d, exp_word(32'h2000));
    f0 = frames;
    do_read(32'h00002004, d);
    chk("R8 sequential word", d, exp_word(32'h2004));
    do_read(32'h00002008, d);
    chk("R8 second sequential word", d, exp_word(32'h2008));
    chk("R8 one frame kept", 32'(frames), 32'(f0));
    do_read(32'h00002040, d);
    chk("R8 jump word", d, exp_word(32'h2040));
    chk("R8 new frame", 32'(frames), 32'(f0 + 1));

    // R7 back-pressure
    @(negedge clk);
    set_cfg(24'h083B91, 8'h3B);
    req_valid = 1'b1;
    req_addr  = 32'h00004400;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    d = resp_data;
    repeat (6) @(negedge clk);
    chk("R7 valid held", 32'(resp_valid), 32'd1);
    chk("R7 data held", resp_data, d);
    chk("R7 word", d, exp_word(32'h4400));
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;

    // R9 enable dropped mid-frame
    @(negedge clk);
    set_cfg(24'h083BA1, 8'h6B);
    req_valid = 1'b1;
    req_addr  = 32'h00009000;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    mm_en = 1'b0;
    @(negedge clk);
    chk("R9 host mode withheld", 32'(host_mode_ok), 32'd0);
    chk("R9 frame still open", 32'(spi_cs_n), 32'd0);
    while (!resp_valid) @(negedge clk);
    chk("R9 word finished", resp_data, exp_word(32'h9000));
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 cs released", 32'(spi_cs_n), 32'd1);
    chk("R9 host mode back", 32'(host_mode_ok), 32'd1);
    req_valid = 1'b1;
    req_addr  = 32'h9004;
    #1;
    chk("R1 no accept after drop", 32'(req_ready), 32'd0);
    req_valid = 1'b0;

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule